// File: doc/BRIEF.md
# Configurable Output Cell with Input Capture Cells

This block is one output slice of a small programmable logic device together with the input conditioning cells that feed its product-term array. The array itself lives outside. The block receives one sum-of-products result and five single-bit control terms: drive enable, force-high, force-low, a private clock and a load enable. From these it produces a pin data value, a pin drive enable and a feedback bit that returns to the array.

Four static configuration bits shape the output path. One chooses between a combinational path and a registered one. One inverts the data on its way to the pin. One picks whether the register is clocked from the shared clock pin or from the private clock term. One turns the register into a D flop with a load enable. A build parameter can fix the cell as active-low only. In that variant the inversion is permanent and the polarity bit is ignored.

Each input cell takes one pin and delivers it to the array in one of three ways: straight through, through a transparent latch, or through a flop.

Top module: `pld_out_cell`

## Requirements
- R1: With `cfg_reg`=0 the pin data `pin_out` equals `sop` XOR the effective inversion, with no clock involved.
- R2: With `cfg_reg`=1 `pin_out` equals the register state XOR the effective inversion. The register takes `sop` on the active edge of the selected clock.
- R3: `pin_oe` is 1 (pin driven) exactly when `pt_oe` is 1 and 0 (high impedance) otherwise, in every mode.
- R4: While `pt_rst` is 1 the register state is 0 at once, without a clock edge. This holds even when `pt_set` is also 1.
- R5: While `pt_set` is 1 and `pt_rst` is 0 the register state is 1 at once, without a clock edge.
- R6: `cfg_clk_pt`=0 clocks the register on rising `clk`. `cfg_clk_pt`=1 clocks it on rising `pt_clk`. Rising edges of the unselected source leave the state unchanged.
- R7: With `cfg_hold_en`=1 a clock edge loads `sop` only when `pt_ena` is 1. Otherwise the state is kept. With `cfg_hold_en`=0, `pt_ena` has no effect.
- R8: Effective inversion is `cfg_inv` (1 = inverted) when `FIXED_LOW`=0. It is always 1, whatever `cfg_inv` is, when `FIXED_LOW`=1.
- R9: `fb` carries the uninverted register state when `cfg_reg`=1 and carries `pin_out` when `cfg_reg`=0.
- R10: Input cell i uses mode bits `in_mode[2i+1:2i]` with these codes: 00 passes the pin straight through, 01 is a latch that is transparent while `clk` is 1, 10 is a flop loaded on rising `clk`, and 11 behaves as 00.
- R11: While `rst_n` is 0 the register state and every input latch and flop are 0.

Because a flop only reacts to edges, the set term only takes effect when it rises or when the clock edges. Deasserting `pt_rst` while `pt_set` stays high therefore leaves the state at 0 until one of those events. Stimulus must not rely on that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin; also the latch gate of the input cells |
| rst_n | input | 1 | Active-low power-up reset |
| cfg_reg | input | 1 | 1 = registered output path, 0 = combinational |
| cfg_inv | input | 1 | 1 = invert data to the pin |
| cfg_clk_pt | input | 1 | 1 = register clocked by `pt_clk`, 0 = by `clk` |
| cfg_hold_en | input | 1 | 1 = register loads only when `pt_ena` is 1 |
| sop | input | 1 | Sum-of-products result from the array |
| pt_oe | input | 1 | Drive-enable product term |
| pt_set | input | 1 | Asynchronous force-to-1 product term |
| pt_rst | input | 1 | Asynchronous force-to-0 product term (wins) |
| pt_clk | input | 1 | Clock product term |
| pt_ena | input | 1 | Load-enable product term |
| in_pin | input | N_IN | Raw input pins |
| in_mode | input | 2*N_IN | Capture mode, two bits per input cell |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin drive enable |
| fb | output | 1 | Feedback bit to the array |
| in_cap | output | N_IN | Captured input values to the array |

## Verification
The delicate overlaps are an asynchronous force and a clock edge meeting in the same cycle, and both force terms being high together. The stimulus raises `pt_rst` and `pt_set` randomly and sometimes together, including steps where the private clock rises while a force is held. One directed step drives both forces at once. The expected pin and feedback come from a bench model that applies reset over set, and set over any load, before it applies an edge. A second overlap is an input pin changing during the latch's transparent phase after the flop has already loaded. The bench judges it by expecting the latch to follow and the flop to keep the value from the edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [1:0] {
    CAP_ASYNC = 2'b00,
    CAP_LATCH = 2'b01,
    CAP_REG   = 2'b10,
    CAP_SPARE = 2'b11
  } cap_mode_e;

  function automatic logic apply_pol(input logic d, input logic inv);
    return d ^ inv;
  endfunction

  function automatic logic load_ok(input logic hold_mode, input logic ena);
    return !hold_mode || ena;
  endfunction

  function automatic logic pick_cap(input logic [1:0] mode, input logic raw,
                                    input logic lat, input logic flop);
    case (mode)
      CAP_LATCH: return lat;
      CAP_REG:   return flop;
      default:   return raw;
    endcase
  endfunction

endpackage

// File: rtl/pld_in_cell.sv
module pld_in_cell
  import pld_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       cap
);

  logic lat_q;
  logic flop_q;

  always_latch begin
    if (!rst_n)   lat_q <= 1'b0;
    else if (clk) lat_q <= pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= pin;
  end

  always_comb cap = pick_cap(mode, pin, lat_q, flop_q);

  // R10: in flop mode the cell shows the pin value seen at the previous edge
  a_r10_flop_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_REG) |=> (mode != CAP_REG || cap == $past(pin)));

endmodule

// File: rtl/pld_out_reg.sv
module pld_out_reg
  import pld_cell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clk_pt,
  input  logic cfg_hold_en,
  input  logic pt_clk,
  input  logic pt_set,
  input  logic pt_rst,
  input  logic pt_ena,
  input  logic d,
  output logic q
);

  logic rclk;
  logic clr_ev;
  logic set_ev;
  logic load_ev;

  always_comb rclk    = cfg_clk_pt ? pt_clk : clk;
  always_comb clr_ev  = pt_rst | ~rst_n;
  always_comb set_ev  = pt_set;
  always_comb load_ev = load_ok(cfg_hold_en, pt_ena);

  always_ff @(posedge rclk or posedge clr_ev or posedge set_ev) begin
    if (clr_ev)       q <= 1'b0;
    else if (set_ev)  q <= 1'b1;
    else if (load_ev) q <= d;
  end

  // R4: reset term holds the state at 0, also against set
  a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rst |-> (q == 1'b0));

  // R5: set term alone holds the state at 1
  a_r5_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_set && !pt_rst) |-> (q == 1'b1));

  // R2 R6: shared clock edge with no force loads the data
  a_r2_edge_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_clk_pt && !pt_set && !pt_rst && load_ev)
    |=> (cfg_clk_pt || pt_set || pt_rst || q == $past(d)));

  // R7: disabled load keeps the state across a shared clock edge
  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_clk_pt && cfg_hold_en && !pt_ena && !pt_set && !pt_rst)
    |=> (cfg_clk_pt || pt_set || pt_rst || $stable(q)));

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter bit FIXED_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reg,
  input  logic              cfg_inv,
  input  logic              cfg_clk_pt,
  input  logic              cfg_hold_en,
  input  logic              sop,
  input  logic              pt_oe,
  input  logic              pt_set,
  input  logic              pt_rst,
  input  logic              pt_clk,
  input  logic              pt_ena,
  input  logic [N_IN-1:0]   in_pin,
  input  logic [2*N_IN-1:0] in_mode,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb,
  output logic [N_IN-1:0]   in_cap
);

  localparam int MODE_W = 2;

  logic inv_eff;
  logic reg_q;
  logic path_d;

  generate
    if (FIXED_LOW) begin : g_fixed_low
      always_comb inv_eff = 1'b1;
    end else begin : g_prog_pol
      always_comb inv_eff = cfg_inv;
    end
  endgenerate

  pld_out_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_clk_pt  (cfg_clk_pt),
    .cfg_hold_en (cfg_hold_en),
    .pt_clk      (pt_clk),
    .pt_set      (pt_set),
    .pt_rst      (pt_rst),
    .pt_ena      (pt_ena),
    .d           (sop),
    .q           (reg_q)
  );

  always_comb path_d  = cfg_reg ? reg_q : sop;
  always_comb pin_out = apply_pol(path_d, inv_eff);
  always_comb pin_oe  = pt_oe;
  always_comb fb      = cfg_reg ? reg_q : pin_out;

  generate
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
      pld_in_cell u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (in_pin[gi]),
        .mode  (in_mode[MODE_W*gi +: MODE_W]),
        .cap   (in_cap[gi])
      );
    end
  endgenerate

  // R9: registered feedback differs from the pin exactly by the inversion
  a_r9_fb_vs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg |-> (fb == (pin_out ^ inv_eff)));

endmodule

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_reg = 1'b1, cfg_inv = 1'b0, cfg_clk_pt = 1'b0, cfg_hold_en = 1'b0;
  logic sop = 1'b0, pt_oe = 1'b0, pt_set = 1'b0, pt_rst = 1'b0;
  logic pt_clk = 1'b0, pt_ena = 1'b0;
  logic [N-1:0]   in_pin = '1;
  logic [2*N-1:0] in_mode = 8'b10_10_10_10;

  logic pin_out, pin_oe, fb, pin_out_fl, pin_oe_fl, fb_fl;
  logic [N-1:0] in_cap, in_cap_fl;

  pld_out_cell #(.N_IN(N), .FIXED_LOW(1'b0)) uut (
    .clk, .rst_n, .cfg_reg, .cfg_inv, .cfg_clk_pt, .cfg_hold_en, .sop, .pt_oe,
    .pt_set, .pt_rst, .pt_clk, .pt_ena, .in_pin, .in_mode,
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb), .in_cap(in_cap));

  pld_out_cell #(.N_IN(N), .FIXED_LOW(1'b1)) uut_fl (
    .clk, .rst_n, .cfg_reg, .cfg_inv, .cfg_clk_pt, .cfg_hold_en, .sop, .pt_oe,
    .pt_set, .pt_rst, .pt_clk, .pt_ena, .in_pin, .in_mode,
    .pin_out(pin_out_fl), .pin_oe(pin_oe_fl), .fb(fb_fl), .in_cap(in_cap_fl));

  int total = 0;
  int bad = 0;
  logic mq = 1'b0;
  logic [N-1:0] lat_m = '0, reg_m = '0;
  logic prev_rst = 1'b0;

  function automatic logic exp_pin(input logic rg, input logic q, input logic d, input logic inv);
    logic v;
    v = rg ? q : d;
    return inv ? ~v : v;
  endfunction

  function automatic logic exp_cap(input logic [1:0] m, input logic raw, input logic l, input logic f);
    if (m == 2'b01) return l;
    if (m == 2'b10) return f;
    return raw;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] ce;
    for (int b = 0; b < N; b++)
      ce[b] = exp_cap(in_mode[2*b +: 2], in_pin[b], lat_m[b], reg_m[b]);
    chk("R1 R2 R8 pin_out", {7'd0, pin_out}, {7'd0, exp_pin(cfg_reg, mq, sop, cfg_inv)});
    chk("R8 fixed-low pin_out", {7'd0, pin_out_fl}, {7'd0, exp_pin(cfg_reg, mq, sop, 1'b1)});
    chk("R3 pin_oe", {6'd0, pin_oe_fl, pin_oe}, {6'd0, pt_oe, pt_oe});
    chk("R9 fb", {7'd0, fb}, {7'd0, cfg_reg ? mq : exp_pin(1'b0, mq, sop, cfg_inv)});
    chk("R10 in_cap", {4'd0, in_cap}, {4'd0, ce});
  endtask

  task automatic drive_rand(input int i);
    if (i % 6 == 0) begin
      cfg_reg     = 1'($urandom);
      cfg_inv     = 1'($urandom);
      cfg_clk_pt  = 1'($urandom);
      cfg_hold_en = 1'($urandom);
      in_mode     = 8'($urandom);
    end
    sop    = 1'($urandom);
    pt_oe  = 1'($urandom);
    pt_ena = 1'($urandom);
    pt_set = ($urandom % 5 == 0);
    pt_rst = ($urandom % 7 == 0);
    if (prev_rst && !pt_rst && pt_set) pt_set = 1'b0;
    in_pin = 4'($urandom);
  endtask

  // one clock step; the caller has just passed a falling clk edge
  task automatic run_step();
    // R4 R5: forces act without a clock, reset first
    if (pt_rst) mq = 1'b0;
    else if (pt_set) mq = 1'b1;
    #1;
    if (cfg_clk_pt) begin
      pt_clk = 1'b1; // R6: private clock edge
      if (!pt_rst && !pt_set && (!cfg_hold_en || pt_ena)) mq = sop;
    end
    #1 check_all();
    @(posedge clk);
    if (!cfg_clk_pt && !pt_rst && !pt_set && (!cfg_hold_en || pt_ena)) mq = sop;
    reg_m = in_pin;
    lat_m = in_pin;
    #2 check_all();
    // R10: pin changes in the transparent phase, latch follows, flop keeps
    in_pin = 4'($urandom);
    lat_m  = in_pin;
    #1 check_all();
    prev_rst = pt_rst;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state, flop-mode inputs read 0 although pins are 1
    chk("R11 reset pin_out", {7'd0, pin_out}, 8'd0);
    chk("R11 reset fb", {7'd0, fb}, 8'd0);
    chk("R11 reset in_cap", {4'd0, in_cap}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    in_pin = '0;

    // R4 directed: set and reset together, reset wins
    @(negedge clk); pt_clk = 1'b0;
    cfg_reg = 1'b1; cfg_inv = 1'b0; cfg_clk_pt = 1'b0; cfg_hold_en = 1'b0;
    sop = 1'b1; pt_set = 1'b1; pt_rst = 1'b1; pt_oe = 1'b1;
    run_step();
    // R5 directed: set alone after a step without reset
    @(negedge clk); pt_clk = 1'b0; pt_rst = 1'b0; pt_set = 1'b0; sop = 1'b0;
    run_step();
    @(negedge clk); pt_clk = 1'b0; pt_set = 1'b1; sop = 1'b0;
    run_step();
    // R7 directed: hold mode with load disabled keeps 1 against sop=0
    @(negedge clk); pt_clk = 1'b0; pt_set = 1'b0; cfg_hold_en = 1'b1; pt_ena = 1'b0;
    run_step();
    // R6 directed: private clock selected, shared edge ignored, private edge loads
    @(negedge clk); pt_clk = 1'b0; cfg_hold_en = 1'b0; cfg_clk_pt = 1'b1; sop = 1'b0;
    run_step();
    // R8 directed: inversion on, combinational path
    @(negedge clk); pt_clk = 1'b0; cfg_clk_pt = 1'b0; cfg_reg = 1'b0; cfg_inv = 1'b1; sop = 1'b1;
    run_step();

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pt_clk = 1'b0;
      drive_rand(i);
      run_step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule